// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one short command on a serial flash device, one bit per serial clock on a single data line. Software describes the whole transaction in one 32-bit control word. The word gives an 8-bit opcode and a set of phases, each with its own enable: an address of three or four bytes, a run of idle clocks, up to eight bytes sent, and up to eight bytes received. A separate word holds the address. Two further words hold the write bytes: the first four bytes sit in the lower word and the next four in the upper word.

The engine does not produce the serial clock or drive the chip select itself. When a command is accepted it pulses `link_start` and raises `link_hold` to a companion timing block. That timing block then sends `bit_sample` at the edge where the flash and the engine capture data, and `bit_shift` when the engine should move to the next bit. After the last bit the engine drops `link_hold`. It keeps `busy` high until the timing block reports through `link_idle` that the select line has been released. Received bytes are returned in two 32-bit result words with the same byte-lane order as the write data.

Top module: `flash_cmd_engine`

## Requirements
- R1: A command starts only on a cycle with `ctrl_wr` high, `ctrl_word[0]` (execute) set and the engine idle. The clock edge that accepts it makes `link_start` high for exactly one cycle and raises `busy` and `link_hold`. A write with bit 0 clear starts nothing.
- R2: Control word fields are: opcode in bits 31:24, read enable in bit 23, read count in 22:20, address enable in bit 19, address count in 17:16, write enable in bit 15, write count in 14:12, and idle-clock count in 11:7. The wire order is opcode, address, idle clocks, write bytes, read bytes. Each byte goes MSB first. A disabled phase (or an idle count of zero) takes no bits. `mosi` is low outside the opcode, address and write phases.
- R3: The address count uses n-1 coding. Value 3 sends all 32 bits of `addr_word` starting at bit 31. Any other value sends only bits 23:0, starting at bit 23.
- R4: The idle-clock field gives the number of bit slots, 0 to 31, inserted after the address. `mosi` is held low during them.
- R5: The write count uses n-1 coding (0 means one byte, 7 means eight). Byte k on the wire is taken from byte lane k of the 64-bit value {`wdata_hi`, `wdata_lo`}, so byte 0 is `wdata_lo[7:0]` and byte 4 is `wdata_hi[7:0]`.
- R6: The read count uses n-1 coding. The first received byte lands in `rdata_lo[7:0]` and the fifth in `rdata_hi[7:0]`. Result bytes beyond the programmed count read as zero.
- R7: The result words change only at the clock edge that takes in the last read bit. They keep their previous value through commands without a read phase.
- R8: `link_hold` stays high from acceptance until the last bit's `bit_shift`. `busy` stays high after that until `link_idle` is seen high.
- R9: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a command.
- R10: An execute request while `busy` is high is ignored. The opcode, fields, address and write data are captured at acceptance, so input changes during a command do not alter it.
- R11: After reset, `busy`, `done`, `link_start`, `link_hold`, `mosi` and both result words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_word | input | 32 | Command description and execute bit |
| addr_word | input | 32 | Flash address for the address phase |
| wdata_lo | input | 32 | Write bytes 0 to 3 |
| wdata_hi | input | 32 | Write bytes 4 to 7 |
| rdata_lo | output | 32 | Received bytes 0 to 3 |
| rdata_hi | output | 32 | Received bytes 4 to 7 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| link_start | output | 1 | One-cycle request to the timing block to open a transaction |
| link_hold | output | 1 | Keep chip select asserted; bits remain |
| link_idle | input | 1 | Timing block reports chip select released |
| bit_shift | input | 1 | Advance to the next bit |
| bit_sample | input | 1 | Capture `miso` for the current bit |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench aims at the phase boundaries. It covers four-byte and three-byte addresses (with nonzero upper address bits that must not go out), 8 and 31 idle clocks, and writes that cross from the lower to the upper data word. A design that decoded a count without the n-1 offset, or reversed the lane order, would send the wrong number of bits or misplaced bytes on the wire. A short read after a full read checks that stale upper bytes are cleared. The bench also checks that the result words hold until the final sampled bit, so an engine that updated them early or cleared them on a non-read command would be caught. A second execute and new inputs during a command must leave the serial stream and the number of start pulses unchanged. The bench also checks that `busy` outlasts `link_hold` until the select is released.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int BUF_W  = 2 * WORD_W;
    localparam int POS_W  = $clog2(BUF_W);
    localparam int APOS_W = $clog2(WORD_W);
    localparam int CNT_W  = POS_W + 1;

    // control word field positions
    localparam int OPC_LSB      = 24;
    localparam int RD_EN_BIT    = 23;
    localparam int RD_CNT_LSB   = 20;
    localparam int ADDR_EN_BIT  = 19;
    localparam int ADDR_CNT_LSB = 16;
    localparam int WR_EN_BIT    = 15;
    localparam int WR_CNT_LSB   = 12;
    localparam int DUMMY_LSB    = 7;
    localparam int EXEC_BIT     = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_WDATA,
        PH_RDATA,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd_en;
        logic [2:0] rd_cnt;
        logic       addr_en;
        logic       addr4;
        logic       wr_en;
        logic [2:0] wr_cnt;
        logic [4:0] dummy;
    } cmd_t;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   bit_cnt;
        cmd_t               cmd;
        logic [WORD_W-1:0]  addr;
        logic [BUF_W-1:0]   wbuf;
        logic [BUF_W-1:0]   rdata;
        logic               busy;
        logic               done;
        logic               start;
        logic               hold;
    } eng_state_t;

    // next enabled phase after cur, in wire order
    function automatic phase_e phase_after(input phase_e cur, input cmd_t c);
        logic try_addr;
        logic try_dummy;
        logic try_wr;
        logic try_rd;
        phase_e res;
        try_addr  = (cur == PH_OPC);
        try_dummy = try_addr  || (cur == PH_ADDR);
        try_wr    = try_dummy || (cur == PH_DUMMY);
        try_rd    = try_wr    || (cur == PH_WDATA);
        if (try_addr && c.addr_en)             res = PH_ADDR;
        else if (try_dummy && c.dummy != 5'd0) res = PH_DUMMY;
        else if (try_wr && c.wr_en)            res = PH_WDATA;
        else if (try_rd && c.rd_en)            res = PH_RDATA;
        else                                   res = PH_FINISH;
        return res;
    endfunction

    // number of bit slots in a phase
    function automatic logic [CNT_W-1:0] phase_bits(input phase_e ph, input cmd_t c);
        logic [CNT_W-1:0] n;
        case (ph)
            PH_OPC:   n = CNT_W'(8);
            PH_ADDR:  n = c.addr4 ? CNT_W'(32) : CNT_W'(24);
            PH_DUMMY: n = CNT_W'(c.dummy);
            PH_WDATA: n = CNT_W'({c.wr_cnt, 3'b000}) + CNT_W'(8);
            PH_RDATA: n = CNT_W'({c.rd_cnt, 3'b000}) + CNT_W'(8);
            default:  n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl,
    output cmd_t              cmd,
    output logic              exec
);

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl[ADDR_CNT_LSB+2], ctrl[DUMMY_LSB-1:EXEC_BIT+1]};

    always_comb begin
        cmd.opcode  = ctrl[OPC_LSB +: 8];
        cmd.rd_en   = ctrl[RD_EN_BIT];
        cmd.rd_cnt  = ctrl[RD_CNT_LSB +: 3];
        cmd.addr_en = ctrl[ADDR_EN_BIT];
        cmd.addr4   = (ctrl[ADDR_CNT_LSB +: 2] == 2'd3);
        cmd.wr_en   = ctrl[WR_EN_BIT];
        cmd.wr_cnt  = ctrl[WR_CNT_LSB +: 3];
        cmd.dummy   = ctrl[DUMMY_LSB +: 5];
        exec        = ctrl[EXEC_BIT];
    end

endmodule

// File: rtl/fcmd_tx_select.sv
module fcmd_tx_select
    import flash_cmd_pkg::*;
(
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [7:0]        opcode,
    input  logic              addr4,
    input  logic [WORD_W-1:0] addr,
    input  logic [BUF_W-1:0]  wbuf,
    output logic              mosi
);

    logic [2:0]        bit_in_byte;
    logic [POS_W-1:0]  wpos;
    logic [APOS_W-1:0] apos;
    logic              unused_cnt_msb;

    assign unused_cnt_msb = bit_cnt[CNT_W-1];
    assign bit_in_byte    = ~bit_cnt[2:0];
    assign wpos           = {bit_cnt[POS_W-1:3], bit_in_byte};
    assign apos           = (addr4 ? APOS_W'(WORD_W - 1) : APOS_W'(23)) - bit_cnt[APOS_W-1:0];

    always_comb begin
        case (phase)
            PH_OPC:   mosi = opcode[bit_in_byte];
            PH_ADDR:  mosi = addr[apos];
            PH_WDATA: mosi = wbuf[wpos];
            default:  mosi = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcmd_rx_assemble.sv
module fcmd_rx_assemble
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample_en,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             miso,
    output logic [BUF_W-1:0] buf_next,
    output logic [BUF_W-1:0] buf_q
);

    logic [BUF_W-1:0] buf_d;
    logic [POS_W-1:0] pos;
    logic             unused_cnt_msb;

    assign unused_cnt_msb = bit_cnt[CNT_W-1];
    assign pos            = {bit_cnt[POS_W-1:3], ~bit_cnt[2:0]};

    always_comb begin
        buf_d = buf_q;
        if (clear) begin
            buf_d = '0;
        end else if (sample_en) begin
            buf_d[pos] = miso;
        end
    end

    assign buf_next = buf_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] addr_word,
    input  logic [WORD_W-1:0] wdata_lo,
    input  logic [WORD_W-1:0] wdata_hi,
    output logic [WORD_W-1:0] rdata_lo,
    output logic [WORD_W-1:0] rdata_hi,
    output logic              busy,
    output logic              done,
    output logic              link_start,
    output logic              link_hold,
    input  logic              link_idle,
    input  logic              bit_shift,
    input  logic              bit_sample,
    output logic              mosi,
    input  logic              miso
);

    eng_state_t q, d;

    cmd_t             dec_cmd;
    logic             dec_exec;
    logic             accept;
    logic             in_bits;
    logic             last_bit;
    logic             rd_sample;
    logic             rd_last;
    logic [BUF_W-1:0] rx_next;
    logic [BUF_W-1:0] rx_buf;
    phase_e           cur_phase;
    phase_e           nxt_phase;

    fcmd_decode u_dec (
        .ctrl (ctrl_word),
        .cmd  (dec_cmd),
        .exec (dec_exec)
    );

    fcmd_tx_select u_tx (
        .phase   (q.phase),
        .bit_cnt (q.bit_cnt),
        .opcode  (q.cmd.opcode),
        .addr4   (q.cmd.addr4),
        .addr    (q.addr),
        .wbuf    (q.wbuf),
        .mosi    (mosi)
    );

    fcmd_rx_assemble u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (rd_sample),
        .bit_cnt   (q.bit_cnt),
        .miso      (miso),
        .buf_next  (rx_next),
        .buf_q     (rx_buf)
    );

    logic unused_rx_buf;
    assign unused_rx_buf = ^rx_buf;

    assign cur_phase = q.phase;
    assign accept    = ctrl_wr && dec_exec && (q.phase == PH_IDLE);
    assign in_bits   = (q.phase != PH_IDLE) && (q.phase != PH_FINISH);
    assign last_bit  = (q.bit_cnt == phase_bits(q.phase, q.cmd) - CNT_W'(1));
    assign rd_sample = (q.phase == PH_RDATA) && bit_sample;
    assign rd_last   = rd_sample && last_bit;
    assign nxt_phase = phase_after(q.phase, q.cmd);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.done  = 1'b0;
        if (accept) begin
            d.cmd     = dec_cmd;
            d.addr    = addr_word;
            d.wbuf    = {wdata_hi, wdata_lo};
            d.phase   = PH_OPC;
            d.bit_cnt = '0;
            d.busy    = 1'b1;
            d.start   = 1'b1;
            d.hold    = 1'b1;
        end else if (in_bits) begin
            if (rd_last) begin
                d.rdata = rx_next;
            end
            if (bit_shift) begin
                if (last_bit) begin
                    d.phase   = nxt_phase;
                    d.bit_cnt = '0;
                    if (nxt_phase == PH_FINISH) begin
                        d.hold = 1'b0;
                    end
                end else begin
                    d.bit_cnt = q.bit_cnt + CNT_W'(1);
                end
            end
        end else if (q.phase == PH_FINISH) begin
            if (link_idle) begin
                d.phase = PH_IDLE;
                d.busy  = 1'b0;
                d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_lo   = q.rdata[WORD_W-1:0];
    assign rdata_hi   = q.rdata[BUF_W-1:WORD_W];
    assign busy       = q.busy;
    assign done       = q.done;
    assign link_start = q.start;
    assign link_hold  = q.hold;

endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker
    import flash_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              link_start,
    input logic              link_hold,
    input logic              mosi,
    input logic [WORD_W-1:0] rdata_lo,
    input logic [WORD_W-1:0] rdata_hi,
    input phase_e            phase
);

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        link_start |-> (busy && link_hold)); // R1

    AST_RD_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RDATA) |-> !mosi); // R2

    AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DUMMY) |-> !mosi); // R4

    AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(rdata_lo) && $stable(rdata_hi))); // R7

    AST_HOLD_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        link_hold |-> busy); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !link_start); // R10

endmodule

bind flash_cmd_engine fcmd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .link_start (link_start),
    .link_hold  (link_hold),
    .mosi       (mosi),
    .rdata_lo   (rdata_lo),
    .rdata_hi   (rdata_hi),
    .phase      (cur_phase)
);

// File: tb/flash_cmd_engine_test.sv
module flash_cmd_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] addr_word = '0;
    logic [31:0] wdata_lo = '0;
    logic [31:0] wdata_hi = '0;
    logic [31:0] rdata_lo;
    logic [31:0] rdata_hi;
    logic        busy;
    logic        done;
    logic        link_start;
    logic        link_hold;
    logic        link_idle = 1'b1;
    logic        bit_shift = 1'b0;
    logic        bit_sample = 1'b0;
    logic        mosi;
    logic        miso = 1'b0;

    int          checks = 0;
    int          failures = 0;
    int          start_cnt = 0;
    logic [63:0] prev_rd = '0;

    always #10 clk = ~clk; // 50 MHz

    flash_cmd_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_word  (ctrl_word),
        .addr_word  (addr_word),
        .wdata_lo   (wdata_lo),
        .wdata_hi   (wdata_hi),
        .rdata_lo   (rdata_lo),
        .rdata_hi   (rdata_hi),
        .busy       (busy),
        .done       (done),
        .link_start (link_start),
        .link_hold  (link_hold),
        .link_idle  (link_idle),
        .bit_shift  (bit_shift),
        .bit_sample (bit_sample),
        .mosi       (mosi),
        .miso       (miso)
    );

    always @(negedge clk) if (link_start === 1'b1) start_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic rd, input int rc,
                                       input logic ae, input int ac, input logic we,
                                       input int wc, input int dm);
        logic [31:0] w = '0;
        w[31:24] = opc;
        w[23]    = rd;
        w[22:20] = rc[2:0];
        w[19]    = ae;
        w[17:16] = ac[1:0];
        w[15]    = we;
        w[14:12] = wc[2:0];
        w[11:7]  = dm[4:0];
        w[0]     = 1'b1;
        return w;
    endfunction

    // runs one command acting as timing block and flash; checks stream and results
    task automatic run_cmd(input logic [31:0] ctrl, input logic [31:0] addr,
                           input logic [31:0] wlo, input logic [31:0] whi,
                           input logic [63:0] model, input bit poke, input string req);
        bit [255:0]  expv = '0;
        bit [255:0]  gotv = '0;
        int          n = 0;
        int          rs;
        int          idx = 0;
        int          bad = 0;
        int          first_bad = -1;
        logic [63:0] wd = {whi, wlo};
        logic [63:0] exp_rd;
        int          rcnt = int'(ctrl[22:20]) + 1;

        for (int i = 7; i >= 0; i--) begin expv[n] = ctrl[24+i]; n++; end
        if (ctrl[19]) begin
            int ab = (ctrl[17:16] == 2'd3) ? 32 : 24;
            for (int i = ab - 1; i >= 0; i--) begin expv[n] = addr[i]; n++; end
        end
        for (int i = 0; i < int'(ctrl[11:7]); i++) begin expv[n] = 1'b0; n++; end
        if (ctrl[15]) begin
            for (int b = 0; b <= int'(ctrl[14:12]); b++)
                for (int j = 0; j < 8; j++) begin expv[n] = wd[b*8 + 7 - j]; n++; end
        end
        rs = n;
        if (ctrl[23]) begin
            for (int i = 0; i < rcnt * 8; i++) begin expv[n] = 1'b0; n++; end
            exp_rd = '0;
            for (int b = 0; b < rcnt; b++) exp_rd[b*8 +: 8] = model[b*8 +: 8];
        end else begin
            exp_rd = prev_rd;
        end

        start_cnt = 0;
        @(negedge clk);
        ctrl_word = ctrl; addr_word = addr; wdata_lo = wlo; wdata_hi = whi; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        chk(link_start === 1'b1 && busy === 1'b1 && link_hold === 1'b1, "R1",
            "start/busy/hold after accept", {61'd0, link_start, busy, link_hold}, 64'd7);
        link_idle = 1'b0;

        while (link_hold === 1'b1 && idx < 260) begin
            gotv[idx] = mosi;
            if (ctrl[23] && idx >= rs) begin
                int r = idx - rs;
                miso = model[(r / 8) * 8 + 7 - (r % 8)];
            end else begin
                miso = 1'b0;
            end
            if (ctrl[23] && idx == n - 1)
                chk({rdata_hi, rdata_lo} === prev_rd, "R7", "result before last sample",
                    {rdata_hi, rdata_lo}, prev_rd);
            bit_sample = 1'b1;
            @(negedge clk);
            bit_sample = 1'b0;
            if (ctrl[23] && idx == n - 1)
                chk({rdata_hi, rdata_lo} === exp_rd, "R7", "result right after last sample",
                    {rdata_hi, rdata_lo}, exp_rd);
            if (poke && idx == 10) begin
                ctrl_word = mk(8'hFF, 1'b1, 7, 1'b1, 3, 1'b1, 7, 31);
                addr_word = ~addr; wdata_lo = ~wlo; wdata_hi = ~whi; ctrl_wr = 1'b1;
            end
            bit_shift = 1'b1;
            @(negedge clk);
            bit_shift = 1'b0;
            ctrl_wr = 1'b0;
            idx++;
        end
        miso = 1'b0;

        for (int i = 0; i < n; i++)
            if (gotv[i] !== expv[i]) begin bad++; if (first_bad < 0) first_bad = i; end
        chk(idx == n, req, "bit slot count", 64'(idx), 64'(n));
        chk(bad == 0, req, "serial stream mismatches (first index in actual)",
            64'(first_bad), 64'(-1));

        chk(busy === 1'b1 && done === 1'b0, "R8", "busy held while select not released",
            {62'd0, busy, done}, 64'd2);
        repeat (2) @(negedge clk);
        chk(busy === 1'b1, "R8", "busy still high before link_idle", 64'(busy), 64'd1);
        link_idle = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b1, "R9", "done with busy fall",
            {62'd0, busy, done}, 64'd1);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done lasts one cycle", 64'(done), 64'd0);
        chk({rdata_hi, rdata_lo} === exp_rd, ctrl[23] ? "R6" : "R7", "result words",
            {rdata_hi, rdata_lo}, exp_rd);
        chk(start_cnt == 1, poke ? "R10" : "R1", "start pulses", 64'(start_cnt), 64'd1);
        prev_rd = exp_rd;
    endtask

    task automatic t_reset;
        chk(busy === 1'b0 && done === 1'b0 && link_start === 1'b0 && link_hold === 1'b0
            && mosi === 1'b0, "R11", "control outputs after reset",
            {59'd0, busy, done, link_start, link_hold, mosi}, 64'd0);
        chk({rdata_hi, rdata_lo} === 64'd0, "R11", "result words after reset",
            {rdata_hi, rdata_lo}, 64'd0);
    endtask

    task automatic t_no_exec;
        start_cnt = 0;
        @(negedge clk);
        ctrl_word = mk(8'h05, 1'b1, 0, 1'b0, 0, 1'b0, 0, 0) & ~32'd1;
        ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && start_cnt == 0, "R1", "write without execute bit",
            {63'd0, busy} | 64'(start_cnt), 64'd0);
    endtask

    task automatic t_opcode_only;
        run_cmd(mk(8'h06, 1'b0, 0, 1'b0, 0, 1'b0, 0, 0), 32'h0, 32'h0, 32'h0,
                64'h0, 1'b0, "R2");
    endtask

    task automatic t_read_three;
        run_cmd(mk(8'h9F, 1'b1, 2, 1'b0, 0, 1'b0, 0, 0), 32'h0, 32'h0, 32'h0,
                64'h1122_3344_5566_7788, 1'b0, "R6");
    endtask

    task automatic t_addr4_write8;
        run_cmd(mk(8'h12, 1'b0, 0, 1'b1, 3, 1'b1, 7, 0), 32'hA1B2_C3D4,
                32'h0403_0201, 32'h0807_0605, 64'h0, 1'b0, "R5");
    endtask

    task automatic t_addr3_dummy_read8;
        run_cmd(mk(8'h0B, 1'b1, 7, 1'b1, 2, 1'b0, 0, 8), 32'hFF12_3456,
                32'h0, 32'h0, 64'hCAFE_BABE_DEAD_BEEF, 1'b0, "R3");
    endtask

    task automatic t_short_read;
        run_cmd(mk(8'h05, 1'b1, 1, 1'b0, 0, 1'b0, 0, 0), 32'h0, 32'h0, 32'h0,
                64'h9999_8888_7777_A55A, 1'b0, "R6");
    endtask

    task automatic t_write_keeps_result;
        run_cmd(mk(8'h01, 1'b0, 0, 1'b0, 0, 1'b1, 0, 0), 32'h0, 32'h0000_00C3, 32'h0,
                64'h0, 1'b0, "R7");
    endtask

    task automatic t_max_dummy;
        run_cmd(mk(8'h5A, 1'b1, 0, 1'b0, 0, 1'b0, 0, 31), 32'h0, 32'h0, 32'h0,
                64'h0000_0000_0000_00B7, 1'b0, "R4");
    endtask

    task automatic t_busy_ignore;
        run_cmd(mk(8'h02, 1'b0, 0, 1'b1, 1, 1'b1, 4, 0), 32'h7700_ABCD,
                32'hDDCC_BBAA, 32'h0000_0011, 64'h0, 1'b1, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_no_exec();
        t_read_three();
        t_opcode_only();
        t_addr4_write8();
        t_addr3_dummy_read8();
        t_short_read();
        t_write_keeps_result();
        t_max_dummy();
        t_busy_ignore();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule